// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a synchronous SRAM with flow-through reads and a data bus that can change direction every clock. It holds a parameterised number of 32-bit words, split into four byte lanes. When the active-low clock enable is asserted, each rising edge registers the address, the three chip enables, the write enable, the load/advance control and the byte write selects. The registered command is a read, a write or a deselect. Read data appears in the cycle after the edge that registered the address. Write data is sampled one qualified edge after its address, so reads and writes can be interleaved with no idle cycle between them.

Each write is held in a one-entry buffer until the next qualified edge. A read of the same word in the meantime takes its bytes from that buffer. A two-bit burst counter steps the low address bits in linear or interleaved order, and a burst keeps the access type of the command that started it. The data-bus driver enable is formed from the internal command state, the asynchronous output enable and a sleep input that stops all new accesses.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low at a rising edge, the registered command becomes deselect and the write buffer is emptied, so `dq_oe` is 0 in the following cycle.
- R2: At an edge where `clk_en_n` is high, every input is ignored and all internal state is held: `dq_oe` and `dq_out` keep their values and no write takes place.
- R3: The block is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 all hold at the same qualified edge. A load edge with any other combination gives `dq_oe`=0 in the next cycle.
- R4: A selected load edge (`adv_ld_n`=0) with `we_n`=1 starts a read. With `oe_n`=0 the word at that address is on `dq_out` with `dq_oe`=1 in the cycle after that edge, with no further register stage.
- R5: A selected load edge with `we_n`=0 starts a write. `dq_oe` is 0 in the cycle after it, and `dq_in` is captured at the next qualified edge as the data for that address.
- R6: Byte write select `bw_n[i]`=0 updates bits 8i+7..8i of the word. A lane whose bit is 1 keeps its old contents.
- R7: A read registered at the edge that captures a write's data, at the same address, returns the newly written lanes merged over the old word, with no idle cycle between them.
- R8: At a qualified edge with `adv_ld_n`=1 after a read or write, the same access type continues and the low two address bits advance. The chip enables and `we_n` are ignored. When `burst_ilv`=0 the offset is (start+count) mod 4. An advance after a deselect stays deselected.
- R9: With `burst_ilv`=1 the low two address bits are start XOR count, so a start of 1 visits 1, 0, 3, 2. `burst_ilv` is a static strap.
- R10: `oe_n`=1 forces `dq_oe` to 0 at once, with no clock edge needed, and `oe_n`=0 restores it during a read cycle.
- R11: While `sleep`=1, `dq_oe` is 0 and qualified edges register a deselect, so reads and writes issued then have no effect. Stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock qualifier, active low |
| addr | input | AW | Word address |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_ld_n | input | 1 | 0 loads a new command, 1 advances the burst |
| bw_n | input | LANES | Byte write selects, active low |
| burst_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-activity request, active high |
| dq_in | input | 8*LANES | Data bus as seen at the pins (write data) |
| dq_out | output | 8*LANES | Read data to the pin drivers |
| dq_oe | output | 1 | Pin driver enable |

## Verification
Read data and `dq_oe` are due in the cycle after the edge that registers the command. The bench drives each command half a period before that edge and samples the outputs half a period after it, at the next falling edge. Write data is placed on `dq_in` in the slot after its command, so it is present at the second qualified edge. That same slot carries the bypass read, whose result is checked one half-period later. Output enable and sleep act combinationally, so they are changed between edges and checked one time unit later with no clock in between.

// File: rtl/zt_pkg.sv
// zt_pkg: types and helpers shared by the zero-turnaround SRAM blocks.
// Assumes a two-bit burst field in the low address bits.
package zt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zt_op_e;

    // Low address bits for burst step cnt from start base, in the chosen order.
    function automatic logic [1:0] burst_off(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/zt_mem.sv
// zt_mem: word array with per-lane write enables and combinational read.
// Assumes a single write port driven by the write buffer; contents not reset.
module zt_mem #(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [LANES-1:0]     wlane,
    input  logic [8*LANES-1:0]   wdata,
    input  logic [AW-1:0]        raddr,
    output logic [8*LANES-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [8*LANES-1:0] store [DEPTH];

    // Commit the selected lanes of one word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wlane[i]) store[waddr][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    // Flow-through read path.
    always_comb rdata = store[raddr];

endmodule

// File: rtl/zt_ctrl.sv
// zt_ctrl: command register and burst counter.
// Registers one command per qualified edge; an advance keeps the access
// type and byte selects of the burst's first command. Sleep forces idle.
module zt_ctrl
    import zt_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qual,
    input  logic              sel,
    input  logic              we_n,
    input  logic              adv_ld_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [AW-1:0]     addr,
    input  logic              ilv,
    input  logic              sleep,
    output zt_op_e            op_q,
    output logic [AW-1:0]     acc_addr,
    output logic [LANES-1:0]  bw_q
);
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;

    // Register a new command, step a burst, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            cnt_q  <= 2'd0;
            base_q <= '0;
            bw_q   <= '1;
        end else if (qual) begin
            if (sleep) begin
                op_q <= OP_IDLE;
            end else if (!adv_ld_n) begin
                cnt_q <= 2'd0;
                if (sel) begin
                    op_q   <= we_n ? OP_READ : OP_WRITE;
                    base_q <= addr;
                    bw_q   <= bw_n;
                end else begin
                    op_q <= OP_IDLE;
                end
            end else if (op_q != OP_IDLE) begin
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    // Effective address: upper bits from the load, low bits from the burst.
    always_comb acc_addr = {base_q[AW-1:2], burst_off(base_q[1:0], cnt_q, ilv)};

endmodule

// File: rtl/zt_wbuf.sv
// zt_wbuf: one-entry late-write buffer with read bypass.
// Data for a write command is taken from the bus at the next qualified edge
// and committed to the array at the qualified edge after that.
module zt_wbuf
    import zt_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                qual,
    input  zt_op_e              op_q,
    input  logic [AW-1:0]       acc_addr,
    input  logic [LANES-1:0]    bw_q,
    input  logic [8*LANES-1:0]  dq_in,
    input  logic [8*LANES-1:0]  mem_rdata,
    output logic                pend_vld,
    output logic                mem_we,
    output logic [AW-1:0]       mem_waddr,
    output logic [LANES-1:0]    mem_wlane,
    output logic [8*LANES-1:0]  mem_wdata,
    output logic [8*LANES-1:0]  rdata
);
    logic              hit;

    // Capture write data one edge after its command; drop it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            mem_waddr <= '0;
            mem_wlane <= '0;
            mem_wdata <= '0;
        end else if (qual) begin
            pend_vld <= (op_q == OP_WRITE);
            if (op_q == OP_WRITE) begin
                mem_waddr <= acc_addr;
                mem_wlane <= ~bw_q;
                mem_wdata <= dq_in;
            end
        end
    end

    // Commit the pending entry on the next qualified edge.
    always_comb mem_we = qual && pend_vld;

    // Pending entry covers the word being read.
    always_comb hit = pend_vld && (mem_waddr == acc_addr);

    // Per-lane bypass mux.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb rdata[8*g +: 8] = (hit && mem_wlane[g]) ? mem_wdata[8*g +: 8]
                                                            : mem_rdata[8*g +: 8];
    end

endmodule

// File: rtl/zt_sram.sv
// zt_sram: flow-through synchronous SRAM with zero bus turnaround.
// Assumes the pin driver applies dq_out when dq_oe is 1 and that dq_in
// shows the bus value; burst_ilv is a static strap.
module zt_sram
    import zt_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en_n,
    input  logic [AW-1:0]       addr,
    input  logic                ce1_n,
    input  logic                ce2,
    input  logic                ce3_n,
    input  logic                we_n,
    input  logic                adv_ld_n,
    input  logic [LANES-1:0]    bw_n,
    input  logic                burst_ilv,
    input  logic                oe_n,
    input  logic                sleep,
    input  logic [8*LANES-1:0]  dq_in,
    output logic [8*LANES-1:0]  dq_out,
    output logic                dq_oe
);
    localparam int DW = 8 * LANES;

    logic              qual;
    logic              sel;
    zt_op_e            op_q;
    logic [AW-1:0]     acc_addr;
    logic [LANES-1:0]  bw_q;
    logic              pend_vld;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [LANES-1:0]  mem_wlane;
    logic [DW-1:0]     mem_wdata;
    logic [DW-1:0]     mem_rdata;
    logic [DW-1:0]     rdata;

    // Edge qualifier and combined chip select.
    always_comb qual = !clk_en_n;
    always_comb sel  = !ce1_n && ce2 && !ce3_n;

    zt_ctrl #(.AW(AW), .LANES(LANES)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .qual(qual), .sel(sel), .we_n(we_n),
        .adv_ld_n(adv_ld_n), .bw_n(bw_n), .addr(addr), .ilv(burst_ilv),
        .sleep(sleep), .op_q(op_q), .acc_addr(acc_addr), .bw_q(bw_q)
    );

    zt_wbuf #(.AW(AW), .LANES(LANES)) i_wbuf (
        .clk(clk), .rst_n(rst_n), .qual(qual), .op_q(op_q),
        .acc_addr(acc_addr), .bw_q(bw_q), .dq_in(dq_in),
        .mem_rdata(mem_rdata), .pend_vld(pend_vld), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wlane(mem_wlane),
        .mem_wdata(mem_wdata), .rdata(rdata)
    );

    zt_mem #(.AW(AW), .LANES(LANES)) i_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wlane(mem_wlane),
        .wdata(mem_wdata), .raddr(acc_addr), .rdata(mem_rdata)
    );

    // Drive only for a read, with output enable low and not asleep.
    always_comb dq_oe  = (op_q == OP_READ) && !oe_n && !sleep;
    always_comb dq_out = dq_oe ? rdata : '0;

endmodule

// File: rtl/zt_sram_chk.sv
// zt_sram_chk: temporal checks on zt_sram, attached by bind.
module zt_sram_chk
    import zt_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   clk_en_n,
    input logic   ce1_n,
    input logic   ce2,
    input logic   ce3_n,
    input logic   we_n,
    input logic   adv_ld_n,
    input logic   oe_n,
    input logic   sleep,
    input logic   dq_oe,
    input zt_op_e op_q,
    input logic   pend_vld
);
    logic sel;
    always_comb sel = !ce1_n && ce2 && !ce3_n;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (op_q == OP_IDLE) && !pend_vld);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(op_q) && $stable(pend_vld));

    p_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld_n && !sel) |=> !dq_oe);

    p_read_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sleep && !adv_ld_n && sel && we_n) |=> (op_q == OP_READ));

    p_write_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE) |-> !dq_oe);

    p_data_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && op_q == OP_WRITE) |=> pend_vld);

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    p_sleep_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && sleep) |=> (op_q == OP_IDLE) && !dq_oe);

endmodule

bind zt_sram zt_sram_chk i_chk (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .adv_ld_n(adv_ld_n),
    .oe_n(oe_n), .sleep(sleep), .dq_oe(dq_oe), .op_q(op_q),
    .pend_vld(pend_vld)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;
    localparam int CLK_P = 10;
    localparam logic [2:0] SEL = 3'b010;   // {ce1_n, ce2, ce3_n}

    typedef struct packed {
        logic        sel;
        logic        we_n;
        logic        adv_n;
        logic [3:0]  bw_n;
        logic [7:0]  addr;
        logic [31:0] din;
        logic        exp_oe;
        logic [31:0] exp_q;
    } vec_t;

    // Back-to-back write/read table: R4 R5 R6 R7 R8
    localparam vec_t VECS [12] = '{
        '{1'b1, 1'b0, 1'b0, 4'b0000, 8'h10, 32'h0000_0000, 1'b0, 32'h0},
        '{1'b1, 1'b0, 1'b0, 4'b0000, 8'h11, 32'hA0A0_0010, 1'b0, 32'h0},
        '{1'b1, 1'b1, 1'b0, 4'b1111, 8'h11, 32'hB1B1_0011, 1'b1, 32'hB1B1_0011},
        '{1'b1, 1'b1, 1'b0, 4'b1111, 8'h10, 32'h0000_0000, 1'b1, 32'hA0A0_0010},
        '{1'b1, 1'b0, 1'b0, 4'b1010, 8'h10, 32'h0000_0000, 1'b0, 32'h0},
        '{1'b1, 1'b1, 1'b0, 4'b1111, 8'h10, 32'h1122_3344, 1'b1, 32'hA022_0044},
        '{1'b0, 1'b1, 1'b0, 4'b1111, 8'h00, 32'h0000_0000, 1'b0, 32'h0},
        '{1'b1, 1'b1, 1'b0, 4'b1111, 8'h10, 32'h0000_0000, 1'b1, 32'hA022_0044},
        '{1'b0, 1'b0, 1'b1, 4'b0000, 8'h77, 32'h0000_0000, 1'b1, 32'hB1B1_0011},
        '{1'b1, 1'b0, 1'b0, 4'b0000, 8'h13, 32'h0000_0000, 1'b0, 32'h0},
        '{1'b0, 1'b1, 1'b0, 4'b1111, 8'h00, 32'hC3C3_0013, 1'b0, 32'h0},
        '{1'b1, 1'b1, 1'b0, 4'b1111, 8'h13, 32'h0000_0000, 1'b1, 32'hC3C3_0013}
    };

    logic        clk = 1'b0;
    logic        rst_n, clk_en_n, ce1_n, ce2, ce3_n, we_n, adv_ld_n;
    logic        burst_ilv, oe_n, sleep;
    logic [7:0]  addr;
    logic [3:0]  bw_n;
    logic [31:0] dq_in, dq_out;
    logic        dq_oe;
    int          n_run = 0;
    int          n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    zt_sram i_zt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .addr(addr),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n),
        .adv_ld_n(adv_ld_n), .bw_n(bw_n), .burst_ilv(burst_ilv),
        .oe_n(oe_n), .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe)
    );

    task automatic chk_oe(input string req, input logic exp);
        n_run++;
        if (dq_oe !== exp) begin
            n_fail++;
            $display("FAIL %s dq_oe actual %b expected %b", req, dq_oe, exp);
        end
    endtask

    task automatic chk_q(input string req, input logic [31:0] exp);
        n_run++;
        if (dq_oe !== 1'b1 || dq_out !== exp) begin
            n_fail++;
            $display("FAIL %s dq_out actual %h (oe %b) expected %h", req, dq_out, dq_oe, exp);
        end
    endtask

    // Drive one command at a falling edge, then wait for the next falling edge.
    task automatic cyc(input logic [2:0] ce, input logic w, input logic adv,
                       input logic [3:0] bw, input logic [7:0] a, input logic [31:0] d);
        {ce1_n, ce2, ce3_n} = ce;
        we_n = w; adv_ld_n = adv; bw_n = bw; addr = a; dq_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; clk_en_n = 1'b0; burst_ilv = 1'b0; oe_n = 1'b0; sleep = 1'b0;
        ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; we_n = 1'b1; adv_ld_n = 1'b0;
        bw_n = 4'hF; addr = '0; dq_in = '0;
        repeat (3) @(negedge clk);
        chk_oe("R1 reset", 1'b0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 12; i++) begin
            cyc(VECS[i].sel ? SEL : 3'b100, VECS[i].we_n, VECS[i].adv_n,
                VECS[i].bw_n, VECS[i].addr, VECS[i].din);
            if (VECS[i].exp_oe) chk_q($sformatf("R4/R7 vec%0d", i), VECS[i].exp_q);
            else chk_oe($sformatf("R5 vec%0d", i), 1'b0);
        end

        // R3: each single wrong chip enable deselects
        cyc(3'b000, 1'b1, 1'b0, 4'hF, 8'h10, '0); chk_oe("R3 ce2 low", 1'b0);
        cyc(3'b011, 1'b1, 1'b0, 4'hF, 8'h10, '0); chk_oe("R3 ce3_n high", 1'b0);
        cyc(3'b110, 1'b1, 1'b0, 4'hF, 8'h10, '0); chk_oe("R3 ce1_n high", 1'b0);

        // R2: held edges ignore a write and keep the read result
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h10, '0); chk_q("R2 pre-hold", 32'hA022_0044);
        clk_en_n = 1'b1;
        cyc(SEL, 1'b0, 1'b0, 4'h0, 8'h11, 32'hDEAD_BEEF); chk_q("R2 hold 1", 32'hA022_0044);
        cyc(SEL, 1'b0, 1'b0, 4'h0, 8'h11, 32'hDEAD_BEEF); chk_q("R2 hold 2", 32'hA022_0044);
        clk_en_n = 1'b0;
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h11, '0); chk_q("R2 no write", 32'hB1B1_0011);

        // R10: output enable acts without a clock edge
        oe_n = 1'b1; #1; chk_oe("R10 oe_n high", 1'b0);
        oe_n = 1'b0; #1; chk_q("R10 oe_n low", 32'hB1B1_0011);

        // Fill 0x20..0x23 with D0000020+i
        cyc(SEL, 1'b0, 1'b0, 4'h0, 8'h20, '0);
        cyc(SEL, 1'b0, 1'b0, 4'h0, 8'h21, 32'hD000_0020);
        cyc(SEL, 1'b0, 1'b0, 4'h0, 8'h22, 32'hD000_0021);
        cyc(SEL, 1'b0, 1'b0, 4'h0, 8'h23, 32'hD000_0022);
        cyc(3'b100, 1'b1, 1'b0, 4'hF, 8'h00, 32'hD000_0023);

        // R9: interleaved from 1 visits 1,0,3,2,1
        burst_ilv = 1'b1;
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h21, '0); chk_q("R9 step0", 32'hD000_0021);
        cyc(3'b100, 1'b0, 1'b1, 4'hF, 8'h00, '0); chk_q("R9 step1", 32'hD000_0020);
        cyc(3'b100, 1'b0, 1'b1, 4'hF, 8'h00, '0); chk_q("R9 step2", 32'hD000_0023);
        cyc(3'b100, 1'b0, 1'b1, 4'hF, 8'h00, '0); chk_q("R9 step3", 32'hD000_0022);
        cyc(3'b100, 1'b0, 1'b1, 4'hF, 8'h00, '0); chk_q("R9 wrap", 32'hD000_0021);
        burst_ilv = 1'b0;

        // R8: linear from 3 wraps to 0
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h23, '0); chk_q("R8 start", 32'hD000_0023);
        cyc(SEL, 1'b1, 1'b1, 4'hF, 8'h00, '0); chk_q("R8 wrap", 32'hD000_0020);
        cyc(SEL, 1'b1, 1'b1, 4'hF, 8'h00, '0); chk_q("R8 next", 32'hD000_0021);
        cyc(3'b100, 1'b1, 1'b0, 4'hF, 8'h00, '0); chk_oe("R8 deselect", 1'b0);
        cyc(SEL, 1'b1, 1'b1, 4'hF, 8'h20, '0); chk_oe("R8 advance after deselect", 1'b0);

        // R8: write burst keeps the write type; R7 bypass on the advanced word
        cyc(SEL, 1'b0, 1'b0, 4'h0, 8'h24, '0); chk_oe("R8 write burst start", 1'b0);
        cyc(SEL, 1'b1, 1'b1, 4'hF, 8'h00, 32'hE000_0024); chk_oe("R8 write burst step", 1'b0);
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h25, 32'hE000_0025); chk_q("R7 burst bypass", 32'hE000_0025);
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h24, '0); chk_q("R8 burst word0", 32'hE000_0024);

        // R11: sleep tristates at once and blocks new accesses
        sleep = 1'b1; #1; chk_oe("R11 immediate", 1'b0);
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h10, '0); chk_oe("R11 read ignored", 1'b0);
        cyc(SEL, 1'b0, 1'b0, 4'h0, 8'h10, '0); chk_oe("R11 write ignored", 1'b0);
        cyc(3'b100, 1'b1, 1'b0, 4'hF, 8'h00, 32'hFFFF_FFFF);
        sleep = 1'b0;
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h10, '0); chk_q("R11 contents kept", 32'hA022_0044);

        // R1: reset mid-read clears the command
        rst_n = 1'b0;
        cyc(SEL, 1'b1, 1'b0, 4'hF, 8'h10, '0); chk_oe("R1 reset mid-run", 1'b0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule